// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns buffered characters into asynchronous serial frames on one output line. Software-side logic presents characters on a valid/ready write port. They are queued in a transmit buffer. An 8-bit line-control input selects the shape of each frame: how many data bits, what kind of parity, how many stop bits, whether the buffer is a multi-entry FIFO or a single holding register, and whether a break is requested.

Bit timing comes from an external baud-tick enable. Each serial bit lasts a fixed number of ticks (16 by default). The line-control fields are copied when a frame begins, so a change made during a frame only affects the frames that follow. A break request is honoured only after the frame in progress has finished. While the break lasts, the buffer holds its contents untouched, and sending resumes from the buffer once the break is released.

The line-control byte uses these bit positions: bit 7 forces a constant parity level, bits 6:5 give the word length, bit 4 turns on the FIFO, bit 3 selects two stop bits, bit 2 selects even parity, bit 1 turns parity on, and bit 0 requests a break.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `txd` is high, `busy` is 0, `wr_ready` is 1 and `tx_full` is 0.
- R2: A frame starts with one low start bit and sends the data bits least significant first. Every bit holds for exactly 16 `baud_tick` pulses, counted from the clock edge at which `txd` falls.
- R3: The word-length field `lctrl[6:5]` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R4: With `lctrl[1]` = 0, no parity bit is sent, whatever `lctrl[7]` and `lctrl[2]` hold.
- R5: With `lctrl[1]` = 1 and `lctrl[7]` = 0, a parity bit follows the data. It makes the count of ones even when `lctrl[2]` = 1 and odd when `lctrl[2]` = 0.
- R6: With `lctrl[1]` = 1 and `lctrl[7]` = 1, the parity bit is the constant 0 when `lctrl[2]` = 1 and the constant 1 when `lctrl[2]` = 0.
- R7: One high stop bit ends the frame when `lctrl[3]` = 0, and two when `lctrl[3]` = 1.
- R8: With `lctrl[4]` = 0, the buffer holds at most one waiting character. `wr_ready` drops and `tx_full` rises as soon as one character waits.
- R9: With `lctrl[4]` = 1, the buffer holds up to 16 waiting characters and sends them in arrival order.
- R10: A change on `lctrl` while a frame is in progress does not alter that frame. The next frame uses the new setting.
- R11: When `lctrl[0]` is set during a frame, that frame completes with its stop bits. After that `txd` stays low for as long as `lctrl[0]` stays set.
- R12: During a break no buffered character is consumed or lost. After `lctrl[0]` clears, the buffered characters are sent in order.
- R13: `busy` is 1 while a frame is being sent or a character waits in the buffer. It falls at the clock edge that ends the last stop bit when nothing waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lctrl | input | 8 | Line-control byte (frame shape, buffer mode, break) |
| baud_tick | input | 1 | One-cycle enable pulse, 16 per serial bit |
| wr_valid | input | 1 | Write request for a character |
| wr_data | input | 8 | Character to transmit |
| wr_ready | output | 1 | Buffer can accept a character this cycle |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | A frame is in progress or a character waits |
| tx_full | output | 1 | Buffer is at capacity for the current mode |

## Verification
The assertions assume that `lctrl` only switches the buffer mode from FIFO to holding while the buffer is empty or during a break. They also assume that `baud_tick` is a single-cycle pulse. The bench keeps within these limits: it drives `baud_tick` on alternate cycles, changes all inputs only on falling clock edges, and changes buffer mode only when the buffer is empty or a break is active. A sweep covers all 64 combinations of the frame-shape fields with distinct data, and a tick-counting receiver model checks every bit and the cycle at which `busy` falls.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef struct packed {
        logic       stick;
        logic [1:0] wlen;
        logic       two_stop;
        logic       even_sel;
        logic       par_en;
    } fcfg_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
    } fshape_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BREAK
    } fstate_e;

    function automatic logic frame_parity(input fcfg_t c, input logic [7:0] d);
        logic [7:0] keep;
        logic       ones;
        keep = 8'hFF >> (2'd3 - c.wlen);
        ones = ^(d & keep);
        if (c.stick) return ~c.even_sel;
        return c.even_sel ? ones : ~ones;
    endfunction

endpackage

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = $clog2(OSR);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick)
            cnt_d = (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_end = tick && !restart && (cnt_q == CW'(OSR - 1));

endmodule

// File: rtl/sftx_tx_buffer.sv
module sftx_tx_buffer #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } bstate_t;

    bstate_t cur, nxt;
    logic    push;
    logic [W-1:0] ents [DEPTH];

    assign full       = fifo_mode ? (cur.cnt >= CW'(DEPTH)) : (cur.cnt != '0);
    assign push_ready = !full;
    assign push       = push_valid && !full;
    assign empty      = (cur.cnt == '0);
    assign level      = cur.cnt;
    assign head       = ents[cur.rp];

    always_comb begin
        nxt = cur;
        if (push) nxt.wp = (cur.wp == AW'(DEPTH - 1)) ? '0 : cur.wp + AW'(1);
        if (pop)  nxt.rp = (cur.rp == AW'(DEPTH - 1)) ? '0 : cur.rp + AW'(1);
        case ({push, pop})
            2'b10:   nxt.cnt = cur.cnt + CW'(1);
            2'b01:   nxt.cnt = cur.cnt - CW'(1);
            default: nxt.cnt = cur.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [W-1:0] ent_d, ent_q;
        always_comb ent_d = (push && cur.wp == AW'(e)) ? push_data : ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end
        assign ents[e] = ent_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cur.cnt <= CW'(DEPTH)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cur.cnt != '0); // R9

endmodule

// File: rtl/sftx_framer.sv
module sftx_framer
    import sftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fcfg_t      cfg_in,
    input  logic       brk_req,
    input  logic       bit_end,
    input  logic       buf_empty,
    input  logic [7:0] buf_head,
    output logic       buf_pop,
    output logic       timer_restart,
    output logic       txd,
    output logic       frame_active,
    output logic       in_break
);
    typedef struct packed {
        fstate_e    st;
        logic [7:0] sh;
        logic [2:0] idx;
        fshape_t    shape;
        logic       par;
    } frm_t;

    frm_t cur, nxt;
    logic [2:0] last_idx;
    logic       txd_c;

    assign last_idx = 3'd4 + {1'b0, cur.shape.wlen};

    always_comb begin
        nxt           = cur;
        buf_pop       = 1'b0;
        timer_restart = 1'b0;
        txd_c         = 1'b1;
        case (cur.st)
            S_IDLE: begin
                if (brk_req) begin
                    nxt.st = S_BREAK;
                end else if (!buf_empty) begin
                    buf_pop        = 1'b1;
                    timer_restart  = 1'b1;
                    nxt.st         = S_START;
                    nxt.sh         = buf_head;
                    nxt.idx        = '0;
                    nxt.shape.wlen     = cfg_in.wlen;
                    nxt.shape.two_stop = cfg_in.two_stop;
                    nxt.shape.par_en   = cfg_in.par_en;
                    nxt.par        = frame_parity(cfg_in, buf_head);
                end
            end
            S_START: begin
                txd_c = 1'b0;
                if (bit_end) nxt.st = S_DATA;
            end
            S_DATA: begin
                txd_c = cur.sh[0];
                if (bit_end) begin
                    nxt.sh = {1'b0, cur.sh[7:1]};
                    if (cur.idx == last_idx) begin
                        nxt.idx = '0;
                        nxt.st  = cur.shape.par_en ? S_PAR : S_STOP1;
                    end else begin
                        nxt.idx = cur.idx + 3'd1;
                    end
                end
            end
            S_PAR: begin
                txd_c = cur.par;
                if (bit_end) nxt.st = S_STOP1;
            end
            S_STOP1: begin
                if (bit_end) nxt.st = cur.shape.two_stop ? S_STOP2 : S_IDLE;
            end
            S_STOP2: begin
                if (bit_end) nxt.st = S_IDLE;
            end
            S_BREAK: begin
                txd_c = 1'b0;
                if (!brk_req) nxt.st = S_IDLE;
            end
            default: nxt.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            cur.st <= S_IDLE;
        end else begin
            cur <= nxt;
        end
    end

    assign txd          = txd_c;
    assign frame_active = (cur.st != S_IDLE) && (cur.st != S_BREAK);
    assign in_break     = (cur.st == S_BREAK);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(cur.st) != S_IDLE && $past(cur.st) != S_BREAK)
        |-> ($stable(cur.shape) && $stable(cur.par))); // R10

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OSR        = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] lctrl,
    input  logic       baud_tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    output logic       txd,
    output logic       busy,
    output logic       tx_full
);
    localparam int LVW = $clog2(FIFO_DEPTH) + 1;

    fcfg_t      fcfg;
    logic       fifo_en, brk_req;
    logic       buf_empty, buf_pop, bit_end, timer_restart;
    logic       frame_active, in_break;
    logic [7:0] buf_head;
    logic [LVW-1:0] level;

    assign fcfg.stick    = lctrl[7];
    assign fcfg.wlen     = lctrl[6:5];
    assign fifo_en       = lctrl[4];
    assign fcfg.two_stop = lctrl[3];
    assign fcfg.even_sel = lctrl[2];
    assign fcfg.par_en   = lctrl[1];
    assign brk_req       = lctrl[0];

    sftx_tx_buffer #(.DEPTH(FIFO_DEPTH), .W(8)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_en),
        .push_valid (wr_valid),
        .push_data  (wr_data),
        .push_ready (wr_ready),
        .pop        (buf_pop),
        .head       (buf_head),
        .empty      (buf_empty),
        .full       (tx_full),
        .level      (level)
    );

    sftx_bit_timer #(.OSR(OSR)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    sftx_framer u_frm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_in        (fcfg),
        .brk_req       (brk_req),
        .bit_end       (bit_end),
        .buf_empty     (buf_empty),
        .buf_head      (buf_head),
        .buf_pop       (buf_pop),
        .timer_restart (timer_restart),
        .txd           (txd),
        .frame_active  (frame_active),
        .in_break      (in_break)
    );

    assign busy = frame_active || !buf_empty;

    AST_BREAK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        in_break |-> !buf_pop); // R12
    AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en) && $past(level) <= LVW'(1)) |-> level <= LVW'(1)); // R8
    AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && $past(in_break)) |-> !txd); // R11

endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lctrl = 8'h00;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready, txd, busy, tx_full;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    serial_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .lctrl(lctrl), .baud_tick(baud_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .txd(txd), .busy(busy), .tx_full(tx_full)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) baud_tick <= 1'b0;
        else        baud_tick <= ~baud_tick;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Receiver model: samples mid-bit by counting ticks after txd falls
    task automatic capture(input logic [7:0] d, input logic [7:0] lc, input bit last, input string tag);
        int nb, total, cnt;
        logic [15:0] expb, got;
        logic ones, par;
        nb = 5 + int'(lc[6:5]);
        ones = 1'b0;
        expb = '1;
        got  = '1;
        expb[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            expb[1+i] = d[i];
            ones ^= d[i];
        end
        par = lc[7] ? ~lc[2] : (lc[2] ? ones : ~ones);
        if (lc[1]) expb[1+nb] = par;
        total = 1 + nb + int'(lc[1]) + 1 + int'(lc[3]);
        while (txd !== 1'b1) @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        for (int b = 0; b < total; b++) begin
            while (cnt < 16*b + 8) begin
                @(negedge clk);
                if (baud_tick) cnt++;
            end
            got[b] = txd;
        end
        check(got == expb, tag, {16'h0, got}, {16'h0, expb});
        while (cnt < 16*total - 1) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
        check(busy === 1'b1, {tag, " R13 busy before end"}, busy, 1);
        while (cnt < 16*total) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
        check(busy === !last, {tag, " R13 busy at end"}, busy, !last);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lc, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd === 1'b1 && busy === 1'b0 && wr_ready === 1'b1 && tx_full === 1'b0,
              "R1 reset", {txd, busy, wr_ready, tx_full}, 4'b1010);

        // Sweep of all frame-shape combinations
        for (int i = 0; i < 64; i++) begin
            lc = {i[5], i[4:3], i[0] ^ i[5], i[2], i[1], i[0], 1'b0};
            d  = 8'((i * 37 + 11) & 8'hFF);
            lctrl = lc;
            fork
                capture(d, lc, 1'b1, "R2 R3 R4 R5 R6 R7 frame");
                write_char(d);
            join
        end

        // R10 mid-frame line-control change
        lctrl = 8'h7E;
        fork
            capture(8'hA5, 8'h7E, 1'b1, "R10 old config frame");
            begin
                write_char(8'hA5);
                while (txd !== 1'b0) @(negedge clk);
                lctrl = 8'h10;
            end
        join
        fork
            capture(8'h3C, 8'h10, 1'b1, "R10 new config frame");
            write_char(8'h3C);
        join

        // R11 break requested during a frame
        lctrl = 8'h7E;
        fork
            capture(8'h96, 8'h7E, 1'b1, "R11 frame completes");
            begin
                write_char(8'h96);
                while (txd !== 1'b0) @(negedge clk);
                lctrl = 8'h7F;
            end
        join
        repeat (5) @(negedge clk);
        check(txd === 1'b0, "R11 line low after frame", txd, 0);
        repeat (200) @(negedge clk);
        check(txd === 1'b0, "R11 line held low", txd, 0);

        // R9 and R12: fill FIFO during break
        for (int k = 0; k < 16; k++) write_char(8'(k * 17 + 3));
        check(wr_ready === 1'b0 && tx_full === 1'b1, "R9 full after 16", {wr_ready, tx_full}, 2'b01);
        repeat (300) @(negedge clk);
        check(txd === 1'b0 && busy === 1'b1 && tx_full === 1'b1, "R12 break keeps buffer",
              {txd, busy, tx_full}, 3'b011);
        lctrl = 8'h7E;
        for (int k = 0; k < 16; k++)
            capture(8'(k * 17 + 3), 8'h7E, k == 15, "R9 R12 resumed frame");

        // R8 holding-register mode
        lctrl = 8'h6F;
        write_char(8'h5A);
        check(wr_ready === 1'b0 && tx_full === 1'b1, "R8 holding full after one",
              {wr_ready, tx_full}, 2'b01);
        lctrl = 8'h6E;
        capture(8'h5A, 8'h6E, 1'b1, "R8 held frame");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule